// File: doc/BRIEF.md
# Endpoint Packet Buffer Access Controller

This block connects a processor's register accesses to the two packet buffers of one USB device endpoint. One buffer holds data going to the host (IN) and one holds data coming from it (OUT). Software moves packets word by word without DMA. To send, software enables the write path, programs a byte count, and stores 32-bit words until that count is covered. The hardware then closes the write. A separate validate command makes the packet eligible for transmission. To receive, software enables the read path and pulls the received words out one at a time.

Each direction has its own enable. Dropping an enable part-way through a packet abandons the transfer, and the next transfer in that direction starts again from word zero. For isochronous endpoints a one-cycle frame-start pulse sets a deadline. An IN buffer that is not validated before the pulse goes out as an empty packet. A received OUT packet that is still unread at the pulse is discarded. The serial bus side is reduced to a word-write port with an end strobe for received packets, and a read address with a "send" strobe for outgoing ones.

Top module: `epbuf_ctrl`

## Requirements
- R1: After reset, wr_en, rd_en, in_full, out_full and tx_avail are 0.
- R2: With wr_en set, writing len_bytes N and then ceil(N/4) words clears wr_en and pulses wr_done in the cycle after the last word. For N = 0, this happens right after the length write. Word k is stored at buffer address k.
- R3: Clearing wr_en mid-packet gives no wr_done. The next enabled packet is written again from address 0.
- R4: A data write while wr_en is 0 changes no buffer word and gives no wr_done.
- R5: Validate sets in_full. On a non-isochronous endpoint (iso_ep = 0), tx_avail follows in_full and tx_len shows the byte count of the last completed packet. tx_send then clears in_full and pulses in_sent.
- R6: On an isochronous endpoint, frame_start sets tx_avail and clears in_full. tx_len becomes the completed byte count if in_full was 1, and 0 (empty packet) otherwise. A validate in the same cycle as frame_start counts toward the following frame.
- R7: rx_end with a nonzero rx_bytes sets out_full and rx_len. While rd_en is 1, rdata shows the packet words in order and each rdata_re advances one word. After the last word, out_full and rd_en drop and out_drained pulses.
- R8: Clearing rd_en mid-packet keeps out_full at 1. The next rd_en set reads again from word 0.
- R9: rdata is 0 while rd_en is 0, and rdata_re then moves no read position.
- R10: On a non-isochronous endpoint, an incoming packet is dropped while out_full is 1. On an isochronous endpoint, it replaces the buffer contents and rx_len.
- R11: On an isochronous endpoint, frame_start clears out_full, losing unread data.
- R12: Both enables may be active together. Data writes and rdata_re in the same cycles work independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_ep | input | 1 | Endpoint is isochronous |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| wr_en_set | input | 1 | Set the write enable |
| wr_en_clr | input | 1 | Clear the write enable (abort) |
| len_we | input | 1 | Write the packet byte count |
| len_bytes | input | 10 | Packet byte count, 0..1023 |
| wdata_we | input | 1 | Write one data word |
| wdata | input | 32 | Data word to store |
| validate | input | 1 | Validate command for the IN buffer |
| wr_en | output | 1 | Write enable state |
| wr_done | output | 1 | Pulse: packet fully written |
| in_full | output | 1 | IN buffer validated |
| in_sent | output | 1 | Pulse: IN packet sent |
| rd_en_set | input | 1 | Set the read enable |
| rd_en_clr | input | 1 | Clear the read enable (abort) |
| rdata_re | input | 1 | Consume one received word |
| rdata | output | 32 | Current received word, 0 when disabled |
| rd_en | output | 1 | Read enable state |
| out_full | output | 1 | OUT buffer holds an unread packet |
| out_drained | output | 1 | Pulse: last received word read |
| rx_len | output | 10 | Byte count of the buffered received packet |
| tx_send | input | 1 | Bus side sends the offered packet |
| tx_raddr | input | 8 | Bus side word address into the IN buffer |
| tx_avail | output | 1 | A packet is offered for transmission |
| tx_len | output | 10 | Byte count of the offered packet |
| tx_rdata | output | 32 | IN buffer word at tx_raddr |
| rx_we | input | 1 | Bus side stores one received word |
| rx_word | input | 32 | Received word |
| rx_end | input | 1 | End of received packet |
| rx_bytes | input | 10 | Byte count of the received packet |

## Verification
Two events can land in the same cycle on an isochronous endpoint: the validate command and the frame-start pulse. The bench drives both in one cycle while the buffer is not yet validated. It expects the hand-off at that boundary to carry an empty packet (tx_len 0), with in_full left set. It then expects the next frame-start to offer the full byte count. The same scheme is used for a data write and a read strobe in the same cycle with both enables on, where each path is judged on its own expected words.

// File: rtl/epbuf_pkg.sv
`timescale 1ns/1ps
package epbuf_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LEN_W  = 10;
    localparam int unsigned CNT_W  = LEN_W - 1;
    localparam int unsigned ADR_W  = LEN_W - 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LEN_W-1:0]  blen_t;
    typedef logic [CNT_W-1:0]  wcnt_t;
    typedef logic [ADR_W-1:0]  addr_t;

    // words needed to carry n bytes, rounded up
    function automatic wcnt_t words_of(input blen_t n);
        logic [LEN_W:0] t;
        t = {1'b0, n} + (LEN_W+1)'(3);
        return wcnt_t'(t >> 2);
    endfunction
endpackage

// File: rtl/epbuf_ram.sv
`timescale 1ns/1ps
module epbuf_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
    assign rdata = mem[raddr];
endmodule

// File: rtl/epbuf_in_path.sv
`timescale 1ns/1ps
module epbuf_in_path
    import epbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  iso,
    input  logic  frame_start,
    input  logic  wen_set,
    input  logic  wen_clr,
    input  logic  len_we,
    input  blen_t len_in,
    input  logic  dat_we,
    input  word_t dat_in,
    input  logic  validate,
    input  logic  tx_send,
    input  addr_t tx_raddr,
    output logic  wen,
    output logic  done,
    output logic  full,
    output logic  sent,
    output logic  tx_avail,
    output blen_t tx_len,
    output word_t tx_rdata
);
    logic  wen_q, loaded_q, done_q, full_q, sent_q, arm_q;
    addr_t ptr_q;
    wcnt_t need_q, ptr_nx;
    blen_t cur_len_q, commit_q, ilen_q;
    logic  wr_fire;

    assign wr_fire = wen_q && loaded_q && dat_we && !wen_set && !wen_clr && !len_we;
    assign ptr_nx  = wcnt_t'(ptr_q) + wcnt_t'(1);

    epbuf_ram #(.AW(ADR_W), .DW(WORD_W)) u_ram (
        .clk(clk), .we(wr_fire), .waddr(ptr_q), .wdata(dat_in),
        .raddr(tx_raddr), .rdata(tx_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q <= 1'b0; loaded_q <= 1'b0; done_q <= 1'b0; full_q <= 1'b0;
            sent_q <= 1'b0; arm_q <= 1'b0; ptr_q <= '0; need_q <= '0;
            cur_len_q <= '0; commit_q <= '0; ilen_q <= '0;
        end else begin
            done_q <= 1'b0;
            sent_q <= tx_send && tx_avail;
            if (wen_set) begin
                wen_q <= 1'b1; ptr_q <= '0; loaded_q <= 1'b0;
            end else if (wen_clr) begin
                wen_q <= 1'b0; ptr_q <= '0; loaded_q <= 1'b0;
            end else if (wen_q && len_we) begin
                cur_len_q <= len_in;
                need_q    <= words_of(len_in);
                ptr_q     <= '0;
                loaded_q  <= 1'b1;
                if (words_of(len_in) == '0) begin
                    wen_q <= 1'b0; loaded_q <= 1'b0; done_q <= 1'b1; commit_q <= len_in;
                end
            end else if (wr_fire) begin
                ptr_q <= ptr_q + addr_t'(1);
                if (ptr_nx == need_q) begin
                    wen_q <= 1'b0; loaded_q <= 1'b0; done_q <= 1'b1;
                    commit_q <= cur_len_q; ptr_q <= '0;
                end
            end
            if (iso) begin
                if (frame_start) begin
                    arm_q  <= 1'b1;
                    ilen_q <= full_q ? commit_q : '0;
                    full_q <= 1'b0;
                end else if (tx_send) begin
                    arm_q <= 1'b0;
                end
            end else if (tx_send) begin
                full_q <= 1'b0;
            end
            if (validate) full_q <= 1'b1;
        end
    end

    assign wen      = wen_q;
    assign done     = done_q;
    assign full     = full_q;
    assign sent     = sent_q;
    assign tx_avail = iso ? arm_q : full_q;
    assign tx_len   = iso ? ilen_q : commit_q;

    assert_done_drops_en_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !wen_q);
    assert_abort_no_done_R3: assert property (@(posedge clk) disable iff (rst)
        (wen_clr && !wen_set) |=> (!done_q && !wen_q));
    assert_validate_full_R5: assert property (@(posedge clk) disable iff (rst)
        validate |=> full_q);
    assert_send_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (!iso && tx_send && !validate) |=> !full_q);
    assert_iso_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (iso && frame_start && !full_q) |=> (arm_q && ilen_q == '0));
endmodule

// File: rtl/epbuf_out_path.sv
`timescale 1ns/1ps
module epbuf_out_path
    import epbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  iso,
    input  logic  frame_start,
    input  logic  ren_set,
    input  logic  ren_clr,
    input  logic  rd_re,
    output word_t rd_data,
    output logic  ren,
    output logic  full,
    output logic  drained,
    output blen_t rx_len,
    input  logic  rx_we,
    input  word_t rx_word,
    input  logic  rx_end,
    input  blen_t rx_bytes
);
    logic  ren_q, full_q, drained_q;
    addr_t rptr_q, bptr_q;
    blen_t len_q;
    word_t mem_rd;
    logic  accept, rx_fire, rd_fire, rd_last;

    assign accept  = iso || !full_q;
    assign rx_fire = rx_we && accept;
    assign rd_fire = ren_q && full_q && rd_re && !ren_set && !ren_clr;
    assign rd_last = rd_fire && ((wcnt_t'(rptr_q) + wcnt_t'(1)) == words_of(len_q));

    epbuf_ram #(.AW(ADR_W), .DW(WORD_W)) u_ram (
        .clk(clk), .we(rx_fire), .waddr(bptr_q), .wdata(rx_word),
        .raddr(rptr_q), .rdata(mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ren_q <= 1'b0; full_q <= 1'b0; drained_q <= 1'b0;
            rptr_q <= '0; bptr_q <= '0; len_q <= '0;
        end else begin
            drained_q <= 1'b0;
            if (rx_fire) bptr_q <= bptr_q + addr_t'(1);
            if (ren_set) begin
                ren_q <= 1'b1; rptr_q <= '0;
            end else if (ren_clr) begin
                ren_q <= 1'b0; rptr_q <= '0;
            end else if (rd_fire) begin
                if (rd_last) begin
                    full_q <= 1'b0; drained_q <= 1'b1; ren_q <= 1'b0; rptr_q <= '0;
                end else begin
                    rptr_q <= rptr_q + addr_t'(1);
                end
            end
            if (iso && frame_start) begin
                full_q <= 1'b0; rptr_q <= '0;
            end
            if (rx_end) begin
                bptr_q <= '0;
                if (accept) begin
                    len_q  <= rx_bytes;
                    full_q <= (words_of(rx_bytes) != '0);
                    rptr_q <= '0;
                end
            end
        end
    end

    assign rd_data = (ren_q && full_q) ? mem_rd : '0;
    assign ren     = ren_q;
    assign full    = full_q;
    assign drained = drained_q;
    assign rx_len  = len_q;

    assert_last_read_drains_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_last && !rx_end && !(iso && frame_start)) |=> (!full_q && drained_q && !ren_q));
    assert_abort_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (ren_clr && !ren_set && full_q && !rx_end && !(iso && frame_start)) |=> full_q);
    assert_iso_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (iso && frame_start && !rx_end) |=> !full_q);
    assert_nak_keeps_len_R10: assert property (@(posedge clk) disable iff (rst)
        (!iso && full_q && rx_end) |=> $stable(len_q));
endmodule

// File: rtl/epbuf_ctrl.sv
`timescale 1ns/1ps
module epbuf_ctrl
    import epbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        iso_ep,
    input  logic        frame_start,
    input  logic        wr_en_set,
    input  logic        wr_en_clr,
    input  logic        len_we,
    input  logic [9:0]  len_bytes,
    input  logic        wdata_we,
    input  logic [31:0] wdata,
    input  logic        validate,
    output logic        wr_en,
    output logic        wr_done,
    output logic        in_full,
    output logic        in_sent,
    input  logic        rd_en_set,
    input  logic        rd_en_clr,
    input  logic        rdata_re,
    output logic [31:0] rdata,
    output logic        rd_en,
    output logic        out_full,
    output logic        out_drained,
    output logic [9:0]  rx_len,
    input  logic        tx_send,
    input  logic [7:0]  tx_raddr,
    output logic        tx_avail,
    output logic [9:0]  tx_len,
    output logic [31:0] tx_rdata,
    input  logic        rx_we,
    input  logic [31:0] rx_word,
    input  logic        rx_end,
    input  logic [9:0]  rx_bytes
);
    epbuf_in_path u_in (
        .clk(clk), .rst(rst), .iso(iso_ep), .frame_start(frame_start),
        .wen_set(wr_en_set), .wen_clr(wr_en_clr), .len_we(len_we), .len_in(len_bytes),
        .dat_we(wdata_we), .dat_in(wdata), .validate(validate), .tx_send(tx_send),
        .tx_raddr(tx_raddr), .wen(wr_en), .done(wr_done), .full(in_full), .sent(in_sent),
        .tx_avail(tx_avail), .tx_len(tx_len), .tx_rdata(tx_rdata)
    );

    epbuf_out_path u_out (
        .clk(clk), .rst(rst), .iso(iso_ep), .frame_start(frame_start),
        .ren_set(rd_en_set), .ren_clr(rd_en_clr), .rd_re(rdata_re), .rd_data(rdata),
        .ren(rd_en), .full(out_full), .drained(out_drained), .rx_len(rx_len),
        .rx_we(rx_we), .rx_word(rx_word), .rx_end(rx_end), .rx_bytes(rx_bytes)
    );
endmodule

// File: tb/sim_epbuf_ctrl.sv
`timescale 1ns/1ps
module sim_epbuf_ctrl;
    logic clk = 1'b0, rst = 1'b1;
    logic iso_ep = 0, frame_start = 0, wr_en_set = 0, wr_en_clr = 0, len_we = 0;
    logic [9:0] len_bytes = '0, rx_bytes = '0, rx_len, tx_len;
    logic wdata_we = 0, validate = 0, rd_en_set = 0, rd_en_clr = 0, rdata_re = 0;
    logic [31:0] wdata = '0, rx_word = '0, rdata, tx_rdata;
    logic wr_en, wr_done, in_full, in_sent, rd_en, out_full, out_drained, tx_avail;
    logic tx_send = 0, rx_we = 0, rx_end = 0;
    logic [7:0] tx_raddr = '0;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    epbuf_ctrl u0 (.*);

    function automatic logic [31:0] pat(input int s, input int i);
        return (32'(s) * 32'h9E3779B9) ^ (32'(i) * 32'h01000193) ^ 32'h5A5A0000;
    endfunction
    function automatic int nwords(input int b);
        return (b + 3) / 4;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        wr_en_set = 0; wr_en_clr = 0; len_we = 0; wdata_we = 0; validate = 0;
        rd_en_set = 0; rd_en_clr = 0; rdata_re = 0; frame_start = 0; tx_send = 0;
        rx_we = 0; rx_end = 0;
    endtask

    task automatic wr_pkt(input int len, input int s);
        wr_en_set = 1; step();
        len_we = 1; len_bytes = 10'(len); step();
        if (nwords(len) == 0) begin
            chk("R2 zero-length done", 32'(wr_done), 1);
            chk("R2 zero-length enable cleared", 32'(wr_en), 0);
        end
        for (int i = 0; i < nwords(len); i++) begin
            wdata_we = 1; wdata = pat(s, i); step();
            if (i == nwords(len) - 1) begin
                chk("R2 done on last word", 32'(wr_done), 1);
                chk("R2 enable auto clear", 32'(wr_en), 0);
            end else if (i == 0) begin
                chk("R2 no early done", 32'(wr_done), 0);
            end
        end
    endtask

    task automatic tx_verify(input int len, input int s, input string tag);
        for (int i = 0; i < nwords(len); i++) begin
            tx_raddr = 8'(i); #1;
            chk(tag, tx_rdata, pat(s, i));
        end
    endtask

    task automatic rx_pkt(input int len, input int s);
        for (int i = 0; i < nwords(len); i++) begin
            rx_we = 1; rx_word = pat(s, i); step();
        end
        rx_end = 1; rx_bytes = 10'(len); step();
    endtask

    task automatic rd_all(input int len, input int s, input string tag);
        rd_en_set = 1; step();
        for (int i = 0; i < nwords(len); i++) begin
            chk(tag, rdata, pat(s, i));
            rdata_re = 1; step();
        end
        chk("R7 out_full cleared", 32'(out_full), 0);
        chk("R7 drained pulse", 32'(out_drained), 1);
        chk("R7 rd_en cleared", 32'(rd_en), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 rd_en", 32'(rd_en), 0);
        chk("R1 in_full", 32'(in_full), 0);
        chk("R1 out_full", 32'(out_full), 0);
        chk("R1 tx_avail", 32'(tx_avail), 0);
        // R2
        wr_pkt(13, 1);
        step();
        chk("R2 done is a pulse", 32'(wr_done), 0);
        tx_verify(13, 1, "R2 stored word");
        wr_pkt(0, 9);
        // R4
        wdata_we = 1; wdata = 32'hDEADBEEF; step();
        chk("R4 no done when disabled", 32'(wr_done), 0);
        tx_verify(13, 1, "R4 buffer unchanged");
        // R3
        wr_en_set = 1; step();
        len_we = 1; len_bytes = 10'd16; step();
        for (int i = 0; i < 2; i++) begin
            wdata_we = 1; wdata = pat(2, i); step();
        end
        wr_en_clr = 1; step();
        chk("R3 abort clears wr_en", 32'(wr_en), 0);
        chk("R3 abort gives no done", 32'(wr_done), 0);
        wr_pkt(8, 3);
        tx_verify(8, 3, "R3 restart at word 0");
        // R5
        validate = 1; step();
        chk("R5 in_full", 32'(in_full), 1);
        chk("R5 tx_avail", 32'(tx_avail), 1);
        chk("R5 tx_len", 32'(tx_len), 8);
        tx_send = 1; step();
        chk("R5 in_sent", 32'(in_sent), 1);
        chk("R5 full cleared", 32'(in_full), 0);
        chk("R5 avail cleared", 32'(tx_avail), 0);
        // R6
        iso_ep = 1; step();
        frame_start = 1; step();
        chk("R6 empty packet avail", 32'(tx_avail), 1);
        chk("R6 empty packet len", 32'(tx_len), 0);
        tx_send = 1; step();
        chk("R6 sent pulse", 32'(in_sent), 1);
        chk("R6 avail after send", 32'(tx_avail), 0);
        validate = 1; step();
        frame_start = 1; step();
        chk("R6 validated len", 32'(tx_len), 8);
        chk("R6 validated state cleared", 32'(in_full), 0);
        validate = 1; frame_start = 1; step();
        chk("R6 late validate sends empty", 32'(tx_len), 0);
        chk("R6 late validate kept", 32'(in_full), 1);
        frame_start = 1; step();
        chk("R6 next frame carries packet", 32'(tx_len), 8);
        iso_ep = 0; step();
        // R7
        rx_pkt(10, 40);
        chk("R7 out_full", 32'(out_full), 1);
        chk("R7 rx_len", 32'(rx_len), 10);
        rd_all(10, 40, "R7 read word");
        // R8 / R9
        rx_pkt(12, 80);
        rd_en_set = 1; step();
        rdata_re = 1; step();
        chk("R8 second word", rdata, pat(80, 1));
        rd_en_clr = 1; step();
        chk("R8 packet kept", 32'(out_full), 1);
        chk("R9 zero when disabled", rdata, 0);
        rdata_re = 1; step();
        chk("R9 read ignored", rdata, 0);
        rd_en_set = 1; step();
        chk("R8 R9 restart at word 0", rdata, pat(80, 0));
        rd_all(12, 80, "R8 reread word");
        // R10 non-isochronous
        rx_pkt(8, 60);
        rx_pkt(4, 61);
        chk("R10 second packet dropped len", 32'(rx_len), 8);
        rd_all(8, 60, "R10 first packet intact");
        // R10 isochronous, R11
        iso_ep = 1;
        rx_pkt(8, 70);
        rx_pkt(4, 71);
        chk("R10 iso overwrite len", 32'(rx_len), 4);
        rd_en_set = 1; step();
        chk("R10 iso overwrite data", rdata, pat(71, 0));
        frame_start = 1; step();
        chk("R11 unread data lost", 32'(out_full), 0);
        chk("R11 rdata zero after loss", rdata, 0);
        rd_en_clr = 1; iso_ep = 0; step();
        // R12
        rx_pkt(16, 50);
        rd_en_set = 1; wr_en_set = 1; step();
        len_we = 1; len_bytes = 10'd16; step();
        for (int i = 0; i < 4; i++) begin
            chk("R12 interleaved read", rdata, pat(50, i));
            wdata_we = 1; wdata = pat(51, i); rdata_re = 1; step();
        end
        chk("R12 write done", 32'(wr_done), 1);
        chk("R12 read drained", 32'(out_drained), 1);
        tx_verify(16, 51, "R12 interleaved write");
        // boundary and random
        wr_pkt(1023, 90);
        tx_verify(1023, 90, "R2 max length word");
        for (int k = 0; k < 16; k++) begin
            int lw, lr;
            lw = int'($urandom_range(0, 1023));
            lr = int'($urandom_range(1, 1023));
            wr_pkt(lw, 200 + k);
            tx_verify(lw, 200 + k, "R2 random write word");
            rx_pkt(lr, 300 + k);
            chk("R7 random rx_len", 32'(rx_len), 32'(lr));
            rd_all(lr, 300 + k, "R7 random read word");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule